// File: doc/BRIEF.md
# Three-Register Crossbar Transfer Unit

This block holds three registers of parameterised width and connects each one to the other two through a dedicated two-way source selector. Each register also has its own load enable. Every register picks its source and decides whether to load on its own. One clock edge can therefore carry out a copy, a swap of two registers, a rotation of all three or a fan-out of one value to the other two, or any mix of independent moves.

All loads read the register contents from before the edge, so the result of a cycle does not depend on any order among the transfers. A synchronous active-high reset clears every register. A preset port overrides the selectors so that the registers can be loaded with known values.

Top module: `xfer_tri_reg`

## Requirements
- R1: While `rst` is 1 at a rising edge, all three registers become zero after that edge, whatever the other inputs are.
- R2: When `rst` is 0 and `preset_en` is 1 at an edge, register k takes `preset_k` for every k, and `sel` and `load` have no effect.
- R3: When `rst` and `preset_en` are 0 and `load[k]` is 0, register k keeps its value across the edge, whatever `sel` is.
- R4: Register 2 (bit 2 of `sel` and `load`) loads the old value of register 0 when `sel[2]`=0 and the old value of register 1 when `sel[2]`=1.
- R5: Register 1 (bit 1) loads the old value of register 0 when `sel[1]`=0 and the old value of register 2 when `sel[1]`=1.
- R6: Register 0 (bit 0) loads the old value of register 2 when `sel[0]`=0 and the old value of register 1 when `sel[0]`=1.
- R7: All loads in a cycle use the values from before the edge. With `sel`=3'b110 and `load`=3'b110, registers 1 and 2 swap in one cycle. With `sel`=3'b100 and `load`=3'b111, register 2 gets register 1, register 1 gets register 0 and register 0 gets register 2.
- R8: With `sel[2]`=0, `sel[1]`=0 and `load`=3'b110, register 0 is copied into both register 1 and register 2 in one cycle, and register 0 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| preset_en | input | 1 | Load all registers from the preset inputs |
| preset_0 | input | W | Preset value for register 0 |
| preset_1 | input | W | Preset value for register 1 |
| preset_2 | input | W | Preset value for register 2 |
| sel | input | 3 | Source select, bit k for register k |
| load | input | 3 | Load enable, bit k for register k |
| q0 | output | W | Register 0 contents |
| q1 | output | W | Register 1 contents |
| q2 | output | W | Register 2 contents |

## Verification
The assertions assume that `sel`, `load` and `preset_en` are known (never X) at each rising edge while reset is low. The bench meets this by driving every input only on falling edges, and it never leaves an input undriven after time zero. Within that limit, the bench walks every one of the 64 `sel`/`load` combinations from several preset patterns whose register values are all distinct, so any wrong source choice shows up as a wrong value. The named swap, rotation and fan-out cases are then repeated on their own, and the preset is applied while `load` is active to show that the selectors are overridden.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int NREG = 3;
  localparam int IDXW = 2;

  // Source register index for register idx given its select bit.
  function automatic logic [IDXW-1:0] src_of(input int idx, input logic s);
    logic [IDXW-1:0] r;
    case (idx)
      2:       r = s ? 2'd1 : 2'd0;
      1:       r = s ? 2'd2 : 2'd0;
      default: r = s ? 2'd1 : 2'd2;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/xfer_src_mux.sv
module xfer_src_mux #(
  parameter int W   = 8,
  parameter int IDX = 0
) (
  input  logic [W-1:0] v0,
  input  logic [W-1:0] v1,
  input  logic [W-1:0] v2,
  input  logic         s,
  output logic [W-1:0] src
);
  import xfer_pkg::*;

  logic [IDXW-1:0] pick;

  always_comb begin
    pick = src_of(IDX, s);
    case (pick)
      2'd0:    src = v0;
      2'd1:    src = v1;
      default: src = v2;
    endcase
  end
endmodule

// File: rtl/xfer_reg_cell.sv
module xfer_reg_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset_en,
  input  logic [W-1:0] preset_val,
  input  logic         ld,
  input  logic [W-1:0] src_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (preset_en) q <= preset_val;
    else if (ld)        q <= src_val;
  end

  p_clear_r1: assert property (@(posedge clk) rst |=> q == '0);
  p_preset_r2: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> q == $past(preset_val));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !ld) |=> $stable(q));
endmodule

// File: rtl/xfer_tri_reg.sv
module xfer_tri_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset_en,
  input  logic [W-1:0] preset_0,
  input  logic [W-1:0] preset_1,
  input  logic [W-1:0] preset_2,
  input  logic [2:0]   sel,
  input  logic [2:0]   load,
  output logic [W-1:0] q0,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2
);
  import xfer_pkg::*;

  logic [W-1:0] q_arr   [NREG];
  logic [W-1:0] src_arr [NREG];
  logic [W-1:0] pre_arr [NREG];

  assign pre_arr[0] = preset_0;
  assign pre_arr[1] = preset_1;
  assign pre_arr[2] = preset_2;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    xfer_src_mux #(.W(W), .IDX(g)) u_mux (
      .v0  (q_arr[0]),
      .v1  (q_arr[1]),
      .v2  (q_arr[2]),
      .s   (sel[g]),
      .src (src_arr[g])
    );
    xfer_reg_cell #(.W(W)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .preset_en  (preset_en),
      .preset_val (pre_arr[g]),
      .ld         (load[g]),
      .src_val    (src_arr[g]),
      .q          (q_arr[g])
    );
  end

  assign q0 = q_arr[0];
  assign q1 = q_arr[1];
  assign q2 = q_arr[2];

  p_r2_src_r4: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && load[2]) |=> q2 == ($past(sel[2]) ? $past(q1) : $past(q0)));
  p_r1_src_r5: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && load[1]) |=> q1 == ($past(sel[1]) ? $past(q2) : $past(q0)));
  p_r0_src_r6: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && load[0]) |=> q0 == ($past(sel[0]) ? $past(q1) : $past(q2)));
  p_swap_r7: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && sel[2:1] == 2'b11 && load == 3'b110)
      |=> (q1 == $past(q2) && q2 == $past(q1)));
  p_fanout_r8: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && sel[2:1] == 2'b00 && load == 3'b110)
      |=> (q1 == $past(q0) && q2 == $past(q0) && $stable(q0)));
endmodule

// File: tb/test_xfer_tri_reg.sv
module test_xfer_tri_reg;
  localparam int W = 8;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic preset_en = 1'b0;
  logic [W-1:0] p0 = '0, p1 = '0, p2 = '0;
  logic [2:0] sel = '0, load = '0;
  logic [W-1:0] q0, q1, q2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  xfer_tri_reg #(.W(W)) i_xfer_tri_reg (
    .clk(clk), .rst(rst), .preset_en(preset_en),
    .preset_0(p0), .preset_1(p1), .preset_2(p2),
    .sel(sel), .load(load), .q0(q0), .q1(q1), .q2(q2)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_preset(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                           input logic [2:0] s, input logic [2:0] l);
    preset_en = 1'b1; p0 = a; p1 = b; p2 = c; sel = s; load = l;
    step();
    preset_en = 1'b0; load = '0;
  endtask

  task automatic do_op(input logic [2:0] s, input logic [2:0] l, input string t2,
                       input string t1, input string t0);
    logic [W-1:0] o0, o1, o2, e0, e1, e2;
    o0 = q0; o1 = q1; o2 = q2;
    e2 = l[2] ? (s[2] ? o1 : o0) : o2;
    e1 = l[1] ? (s[1] ? o2 : o0) : o1;
    e0 = l[0] ? (s[0] ? o1 : o2) : o0;
    sel = s; load = l;
    step();
    load = '0;
    chk(l[2] ? t2 : "R3", q2, e2);
    chk(l[1] ? t1 : "R3", q1, e1);
    chk(l[0] ? t0 : "R3", q0, e0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    sel = 3'b111; load = 3'b111; preset_en = 1'b1; p0 = 8'hAA; p1 = 8'hBB; p2 = 8'hCC;
    step();
    step();
    chk("R1", q0, '0); chk("R1", q1, '0); chk("R1", q2, '0);
    rst = 1'b0; preset_en = 1'b0; load = '0;

    // preset overrides an active load
    do_preset(8'h12, 8'h34, 8'h56, 3'b000, 3'b111);
    chk("R2", q0, 8'h12); chk("R2", q1, 8'h34); chk("R2", q2, 8'h56);

    // reset wins over preset
    rst = 1'b1; preset_en = 1'b1; step(); rst = 1'b0; preset_en = 1'b0;
    chk("R1", q0, '0); chk("R1", q1, '0); chk("R1", q2, '0);

    // exhaustive sweep of sel x load from several distinct patterns
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 8; s++) begin
        for (int l = 0; l < 8; l++) begin
          do_preset(W'(8'h11 + 8'h21 * k), W'(8'h5A ^ (8'h13 * k)), W'(8'hC3 - 8'h07 * k),
                    3'b000, 3'b000);
          do_op(3'(s), 3'(l), "R4", "R5", "R6");
        end
      end
    end

    // swap of registers 2 and 1
    do_preset(8'h01, 8'h02, 8'h03, 3'b000, 3'b000);
    do_op(3'b110, 3'b110, "R7", "R7", "R7");
    chk("R7", q1, 8'h03); chk("R7", q2, 8'h02);

    // rotation
    do_preset(8'hA0, 8'hB1, 8'hC2, 3'b000, 3'b000);
    do_op(3'b100, 3'b111, "R7", "R7", "R7");
    chk("R7", q2, 8'hB1); chk("R7", q1, 8'hA0); chk("R7", q0, 8'hC2);

    // fan-out of register 0
    do_preset(8'h5C, 8'h00, 8'hFF, 3'b000, 3'b000);
    do_op(3'b000, 3'b110, "R8", "R8", "R8");
    chk("R8", q0, 8'h5C); chk("R8", q1, 8'h5C); chk("R8", q2, 8'h5C);

    // all loads off: selectors have no effect
    do_preset(8'h77, 8'h88, 8'h99, 3'b000, 3'b000);
    do_op(3'b101, 3'b000, "R3", "R3", "R3");
    chk("R3", q0, 8'h77); chk("R3", q1, 8'h88); chk("R3", q2, 8'h99);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule